// File: doc/BRIEF.md
# Tile Network Interface Controller

This controller sits between a circuit-switched on-chip network and one reconfigurable tile processor. A 16-bit command stream arrives from the network. Each command is a header word, and some headers are followed by a length word and a run of data words. The commands configure the tile, move data into its local memories, read results back out of them, start the tile, wait for it to finish, and reset it. The block also decides when the tile may run. The tile is held halted while a block-mode transfer uses its memories. Its program counter is frozen while configuration words are rewritten.

In block mode the host issues three phases in order: a load of the input data, then start and wait, then a retrieve of the results. In streaming mode the tile runs and its own instructions read and write up to four 16-bit network channels in parallel. The controller then acts only as a slave. It passes words through, and it stalls the tile when a channel cannot supply or accept a word.

Top module: `tile_net_if`

## Requirements
- R1: A header word carries the opcode in bits 15:13, a memory index in bits 12:11 and a start address in bits 10:0. Opcodes are 0 no-op, 1 configure, 2 load, 3 retrieve, 4 start, 5 wait, 6 reset, 7 stream. Configure, load and retrieve take a second word that gives the word count. A count of zero ends the command with no transfer.
- R2: Load writes each following data word to the indexed memory at consecutive addresses from the start address. tile_halt is high during every such write and falls back after the last write if the tile was running.
- R3: Retrieve presents the memory word at the current address on out_data with out_valid high. The memory read port is combinational. The address advances only when out_ready is high. No command is accepted until the count is exhausted.
- R4: Configure writes the data words to the configuration memory at consecutive addresses from the start address. pc_freeze is high from acceptance of the header until the last word, and the tile is not halted for this.
- R5: Start pulses tile_start for one cycle and lets the tile run, so tile_halt is low.
- R6: Wait makes busy high and cmd_ready low until tile_done is seen. done then goes high, busy falls, and the tile is halted. done clears when the next header is accepted.
- R7: Reset pulses tile_rst for one cycle, halts the tile and leaves streaming mode.
- R8: Stream with address bit 0 set enters streaming mode and runs the tile. With bit 0 clear it leaves streaming mode. In streaming mode each of four channels passes data between its network side and its tile side independently.
- R9: A tile read on a channel with no valid input word raises that channel's read stall. A tile write on a channel whose network side is not ready raises its write stall. Outside streaming mode every request stalls, and the network sees no ready and no valid.
- R10: After reset, busy, done, pc_freeze and out_valid are low, cmd_ready is high and the tile is halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Command word accepted |
| cmd_data | input | 16 | Command word |
| out_valid | output | 1 | Retrieved word valid |
| out_ready | input | 1 | Network accepts retrieved word |
| out_data | output | 16 | Retrieved word |
| mem_sel | output | 2 | Local memory index |
| mem_addr | output | 11 | Local memory address |
| mem_we | output | 1 | Local memory write |
| mem_wdata | output | 16 | Local memory write data |
| mem_re | output | 1 | Local memory read |
| mem_rdata | input | 16 | Local memory read data (combinational) |
| cfg_we | output | 1 | Configuration memory write |
| cfg_addr | output | 11 | Configuration memory address |
| cfg_wdata | output | 16 | Configuration write data |
| pc_freeze | output | 1 | Freeze tile program counter |
| tile_halt | output | 1 | Hold tile halted |
| tile_start | output | 1 | Start pulse |
| tile_rst | output | 1 | Computation reset pulse |
| tile_done | input | 1 | Tile completion flag |
| busy | output | 1 | Command in progress |
| done | output | 1 | Wait completed |
| sin_valid | input | 4 | Per-channel network input valid |
| sin_data | input | 64 | Per-channel network input data |
| sin_ready | output | 4 | Per-channel network input consumed |
| tp_rd | input | 4 | Per-channel tile read request |
| tp_rd_data | output | 64 | Per-channel tile read data |
| tp_rd_stall | output | 4 | Per-channel tile read stall |
| tp_wr | input | 4 | Per-channel tile write request |
| tp_wr_data | input | 64 | Per-channel tile write data |
| tp_wr_stall | output | 4 | Per-channel tile write stall |
| sout_valid | output | 4 | Per-channel network output valid |
| sout_data | output | 64 | Per-channel network output data |
| sout_ready | input | 4 | Per-channel network output ready |

## Verification
The bench checks a zero-length transfer. A design that miscounted it would hang waiting for data words or write one stray word. Retrieve is run under out_ready backpressure that toggles every cycle. A design that advanced on valid alone would skip or repeat result words. Configuration is written while the tile runs, to catch a design that halts the tile instead of only freezing its program counter, or that drops the freeze early. Channel masks are mixed so each channel must stall on its own rather than on a shared condition.

// File: rtl/tile_net_if.sv
module tile_net_if #(
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int AW  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [DW-1:0]     cmd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic [1:0]        mem_sel,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_we,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_re,
  input  logic [DW-1:0]     mem_rdata,
  output logic              cfg_we,
  output logic [AW-1:0]     cfg_addr,
  output logic [DW-1:0]     cfg_wdata,
  output logic              pc_freeze,
  output logic              tile_halt,
  output logic              tile_start,
  output logic              tile_rst,
  input  logic              tile_done,
  output logic              busy,
  output logic              done,
  input  logic [NCH-1:0]    sin_valid,
  input  logic [NCH*DW-1:0] sin_data,
  output logic [NCH-1:0]    sin_ready,
  input  logic [NCH-1:0]    tp_rd,
  output logic [NCH*DW-1:0] tp_rd_data,
  output logic [NCH-1:0]    tp_rd_stall,
  input  logic [NCH-1:0]    tp_wr,
  input  logic [NCH*DW-1:0] tp_wr_data,
  output logic [NCH-1:0]    tp_wr_stall,
  output logic [NCH-1:0]    sout_valid,
  output logic [NCH*DW-1:0] sout_data,
  input  logic [NCH-1:0]    sout_ready
);

  localparam logic [2:0] OP_CFG  = 3'd1;
  localparam logic [2:0] OP_LOAD = 3'd2;
  localparam logic [2:0] OP_RET  = 3'd3;
  localparam logic [2:0] OP_GO   = 3'd4;
  localparam logic [2:0] OP_WAIT = 3'd5;
  localparam logic [2:0] OP_RST  = 3'd6;
  localparam logic [2:0] OP_STRM = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_LEN, S_CFG, S_LOAD, S_RET, S_WAIT} st_t;

  st_t           st;
  logic [2:0]    op_q;
  logic [1:0]    idx_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] cnt_q;
  logic          run_q, smode_q, done_q;

  wire [2:0] hop  = cmd_data[DW-1:DW-3];
  assign cmd_ready = (st == S_IDLE) || (st == S_LEN) || (st == S_CFG) || (st == S_LOAD);
  wire hdr  = cmd_valid && st == S_IDLE;
  wire step = ((st == S_CFG || st == S_LOAD) && cmd_valid) || (st == S_RET && out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= '0;
      idx_q   <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      smode_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (hdr) done_q <= 1'b0;
      if (step) begin
        addr_q <= addr_q + 1'b1;
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == 1) st <= S_IDLE;
      end
      case (st)
        S_IDLE: if (hdr) begin
          case (hop)
            OP_CFG, OP_LOAD, OP_RET: begin
              op_q   <= hop;
              idx_q  <= cmd_data[12:11];
              addr_q <= cmd_data[AW-1:0];
              st     <= S_LEN;
            end
            OP_GO:   run_q <= 1'b1;
            OP_WAIT: st <= S_WAIT;
            OP_RST: begin
              run_q   <= 1'b0;
              smode_q <= 1'b0;
            end
            OP_STRM: begin
              run_q   <= cmd_data[0];
              smode_q <= cmd_data[0];
            end
            default: ;
          endcase
        end
        S_LEN: if (cmd_valid) begin
          cnt_q <= cmd_data;
          if (cmd_data == '0)     st <= S_IDLE;
          else if (op_q == OP_CFG)  st <= S_CFG;
          else if (op_q == OP_LOAD) st <= S_LOAD;
          else                      st <= S_RET;
        end
        S_WAIT: if (tile_done) begin
          done_q <= 1'b1;
          run_q  <= 1'b0;
          st     <= S_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign mem_sel    = idx_q;
  assign mem_addr   = addr_q;
  assign mem_we     = st == S_LOAD && cmd_valid;
  assign mem_wdata  = cmd_data;
  assign mem_re     = st == S_RET;
  assign out_valid  = st == S_RET;
  assign out_data   = mem_rdata;
  assign cfg_we     = st == S_CFG && cmd_valid;
  assign cfg_addr   = addr_q;
  assign cfg_wdata  = cmd_data;
  assign pc_freeze  = st == S_CFG || (st == S_LEN && op_q == OP_CFG);
  assign tile_halt  = !run_q || st == S_LOAD || st == S_RET || (st == S_LEN && op_q != OP_CFG);
  assign tile_start = hdr && hop == OP_GO;
  assign tile_rst   = hdr && hop == OP_RST;
  assign busy       = st != S_IDLE;
  assign done       = done_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign sin_ready[c]            = smode_q && tp_rd[c];
    assign tp_rd_stall[c]          = tp_rd[c] && !(smode_q && sin_valid[c]);
    assign tp_rd_data[c*DW +: DW]  = sin_data[c*DW +: DW];
    assign sout_valid[c]           = smode_q && tp_wr[c];
    assign tp_wr_stall[c]          = tp_wr[c] && !(smode_q && sout_ready[c]);
    assign sout_data[c*DW +: DW]   = tp_wr_data[c*DW +: DW];
  end

  assert_count_live_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CFG || st == S_LOAD || st == S_RET) |-> cnt_q != '0);
  assert_load_halted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> tile_halt);
  assert_retrieve_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!cmd_ready && tile_halt));
  assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> pc_freeze);
  assert_done_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(tile_done));

endmodule

// File: tb/test_tile_net_if.sv
`timescale 1ns/1ps
module test_tile_net_if;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic        cmd_valid = 0, out_ready = 0, tile_done = 0;
  logic [15:0] cmd_data = 0;
  logic        cmd_ready, out_valid, mem_we, mem_re, cfg_we, pc_freeze, tile_halt;
  logic        tile_start, tile_rst, busy, done;
  logic [15:0] out_data, mem_wdata, mem_rdata, cfg_wdata;
  logic [1:0]  mem_sel;
  logic [10:0] mem_addr, cfg_addr;
  logic [3:0]  sin_valid = 0, sin_ready, tp_rd = 0, tp_rd_stall, tp_wr = 0, tp_wr_stall;
  logic [3:0]  sout_valid, sout_ready = 0;
  logic [63:0] sin_data = 0, tp_rd_data, tp_wr_data = 0, sout_data;

  tile_net_if i_tile_net_if (.*);

  logic [15:0] mem_m [0:127];
  logic [15:0] cfg_m [0:31];
  assign mem_rdata = mem_m[{mem_sel, mem_addr[4:0]}];

  int checks = 0, errors = 0;
  int we_n = 0, halt_bad = 0, cfg_n = 0, frz_bad = 0, cfg_halted = 0, start_n = 0, trst_n = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (mem_we) begin
      mem_m[{mem_sel, mem_addr[4:0]}] <= mem_wdata;
      we_n++;
      if (!tile_halt) halt_bad++;
    end
    if (cfg_we) begin
      cfg_m[cfg_addr[4:0]] <= cfg_wdata;
      cfg_n++;
      if (!pc_freeze) frz_bad++;
      if (tile_halt) cfg_halted++;
    end
    if (tile_start) start_n++;
    if (tile_rst) trst_n++;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(logic [15:0] w);
    cmd_data = w;
    cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  function automatic logic [15:0] hw(logic [2:0] op, logic [1:0] ix, logic [10:0] a);
    return {op, ix, a};
  endfunction

  localparam logic [31:0] VEC [6] = '{
    32'hFFFF_0F0F, 32'hF0F0_FFFF, 32'h53AC_452A,
    32'h0F0F_0000, 32'h9864_1926, 32'hC431_8C23 };

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rx [3];
    int got, w0;
    for (int i = 0; i < 128; i++) mem_m[i] = 16'h0;
    for (int i = 0; i < 32; i++) cfg_m[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 ready", cmd_ready, 1);
    chk("R10 halt", tile_halt, 1);
    chk("R10 freeze/out", {pc_freeze, out_valid}, 0);

    send(hw(3'd4, 0, 0));
    chk("R5 start pulse", start_n, 1);
    chk("R5 running", tile_halt, 0);

    send(hw(3'd2, 2'd2, 11'd5));
    send(16'd3);
    send(16'hA001); send(16'hA002); send(16'hA003);
    chk("R2 mem5", mem_m[{2'd2, 5'd5}], 16'hA001);
    chk("R2 mem7", mem_m[{2'd2, 5'd7}], 16'hA003);
    chk("R2 writes", we_n, 3);
    chk("R2 halted during load", halt_bad, 0);
    chk("R2 resumes", tile_halt, 0);

    w0 = we_n;
    send(hw(3'd2, 2'd1, 11'd0));
    send(16'd0);
    chk("R1 zero length no write", we_n, w0);
    chk("R1 zero length idle", {busy, cmd_ready}, 2'b01);

    send(hw(3'd1, 0, 11'd3));
    chk("R4 freeze at header", pc_freeze, 1);
    send(16'd2);
    send(16'hC003); send(16'hC004);
    chk("R4 cfg3", cfg_m[3], 16'hC003);
    chk("R4 cfg4", cfg_m[4], 16'hC004);
    chk("R4 writes frozen", {cfg_n, frz_bad}, {32'd2, 32'd0});
    chk("R4 not halted", cfg_halted, 0);
    chk("R4 released", pc_freeze, 0);

    send(hw(3'd3, 2'd2, 11'd5));
    send(16'd3);
    got = 0;
    for (int k = 0; k < 30 && got < 3; k++) begin
      out_ready = k[0];
      if (out_valid) chk("R3 commands blocked", cmd_ready, 0);
      if (out_valid && out_ready) begin rx[got] = out_data; got++; end
      @(negedge clk);
    end
    out_ready = 0;
    chk("R3 word0", rx[0], 16'hA001);
    chk("R3 word1", rx[1], 16'hA002);
    chk("R3 word2", rx[2], 16'hA003);
    chk("R3 finished", {out_valid, busy}, 0);

    send(hw(3'd5, 0, 0));
    repeat (3) @(negedge clk);
    chk("R6 waiting", {busy, cmd_ready, tile_halt, done}, 4'b1000);
    tile_done = 1;
    @(negedge clk);
    tile_done = 0;
    chk("R6 completed", {busy, done, tile_halt}, 3'b011);
    send(hw(3'd0, 0, 0));
    chk("R6 done cleared", done, 0);

    send(hw(3'd7, 0, 11'd1));
    chk("R8 stream runs", tile_halt, 0);
    for (int v = 0; v < 6; v++) begin
      tp_rd = VEC[v][31:28]; sin_valid = VEC[v][27:24];
      tp_wr = VEC[v][23:20]; sout_ready = VEC[v][19:16];
      #1;
      chk("R9 read stall", tp_rd_stall, VEC[v][15:12]);
      chk("R8 input ready", sin_ready, VEC[v][11:8]);
      chk("R9 write stall", tp_wr_stall, VEC[v][7:4]);
      chk("R8 output valid", sout_valid, VEC[v][3:0]);
      @(negedge clk);
    end
    sin_data = 64'h1111_2222_3333_4444;
    tp_wr_data = 64'h5555_6666_7777_8888;
    #1;
    chk("R8 read data", tp_rd_data, 64'h1111_2222_3333_4444);
    chk("R8 write data", sout_data, 64'h5555_6666_7777_8888);
    @(negedge clk);

    send(hw(3'd7, 0, 11'd0));
    tp_rd = 4'hF; sin_valid = 4'hF; tp_wr = 4'hF; sout_ready = 4'hF;
    #1;
    chk("R9 off stalls", {tp_rd_stall, tp_wr_stall}, 8'hFF);
    chk("R9 off quiet", {sin_ready, sout_valid}, 8'h00);
    @(negedge clk);

    send(hw(3'd7, 0, 11'd1));
    chk("R8 back on", sout_valid, 4'hF);
    send(hw(3'd6, 0, 0));
    chk("R7 reset pulse", trst_n, 1);
    chk("R7 halted", tile_halt, 1);
    chk("R7 stream dropped", sout_valid, 4'h0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule